// File: doc/BRIEF.md
# Operator PIN Authentication and Lockout Controller

This block decides who the operator is. An operator first enrolls one 24-bit PIN, written as six hex digits, and binds a role to it. A later login attempt presents a PIN and names the role it wants. The block grants that role if the PIN matches and the role is covered by the enrolled one. Only one session exists at a time. Any new attempt ends the session that was open, so a role change always needs a fresh login.

Failed attempts are counted, and any success clears the count. When the count reaches its limit, the block raises a zeroize request for a fixed number of cycles. This asks the rest of the chip to clear its volatile secrets and reset. Attempts made while that request is up are dropped without any response.

After power-on, or after a full wipe, nothing is enrolled. In that state every attempt is refused, and only the open status-type services are granted. A small service gate turns the current role into a grant for each service code.

Top module: `pin_guard`

## Requirements
- R1: Reset state: during and after the active-low synchronous reset, `role` is 2'b00, `auth_ok`, `auth_fail` and `zeroize_req` are 0, and `enroll_needed` is 1.
- R2: Enrollment: while `enroll_needed` is 1, a cycle with `enroll_valid` and a nonzero `enroll_role` stores the PIN and role, and `enroll_needed` reads 0 from the next cycle. Enrollment leaves `role` at 2'b00. An enrollment with role 2'b00, or one made while a PIN is already enrolled, has no effect.
- R3: While nothing is enrolled, an attempt gives a one-cycle `auth_fail` in the cycle after it. It does not add to the failure count, and `role` stays 2'b00.
- R4: Role encoding: bit 0 is User and bit 1 is Crypto-Officer, so 2'b11 is both. An attempt succeeds when the PIN is equal to the enrolled PIN and the requested role is nonzero with no bit outside the enrolled role. On success, `role` takes the requested value and `auth_ok` pulses for one cycle, in the cycle after the attempt.
- R5: Every accepted attempt ends the previous session. A failed attempt leaves `role` at 2'b00 and gives a one-cycle `auth_fail` in the cycle after it.
- R6: When failed attempts against an enrolled PIN reach MAX_FAIL (default 5) in a row, `zeroize_req` rises together with the fifth `auth_fail`. It stays high for exactly HOLD_CYC cycles (default 4), then falls.
- R7: A successful attempt sets the failure count back to zero.
- R8: While `zeroize_req` is high, attempts are ignored: no `auth_ok`, no `auth_fail`, no change of `role`, and no counting.
- R9: A cycle with `wipe_all` clears the enrolled PIN and role, the session, the failure count and any pending zeroize. From the next cycle, `enroll_needed` is 1 and `role` is 2'b00. Nothing else is acted on in that cycle.
- R10: `svc_ok` grants service codes 0 to 3 always. Codes 4 and 5 need `role` bit 0, and codes 6 and 7 need `role` bit 1.
- R11: When `zeroize_req` falls, the failure count starts again from zero, and the enrolled PIN is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| try_valid | input | 1 | Login attempt strobe |
| try_pin | input | PIN_W | PIN presented with the attempt |
| try_role | input | 2 | Role requested by the attempt |
| enroll_valid | input | 1 | Enrollment strobe |
| enroll_pin | input | PIN_W | PIN to enroll |
| enroll_role | input | 2 | Role bound to the enrolled PIN |
| wipe_all | input | 1 | Full zeroize: drop enrollment and session |
| svc_sel | input | 3 | Service code being requested |
| role | output | 2 | Role of the current session |
| auth_ok | output | 1 | One-cycle pulse for a granted attempt |
| auth_fail | output | 1 | One-cycle pulse for a refused attempt |
| zeroize_req | output | 1 | Access-lockout zeroize request |
| enroll_needed | output | 1 | No PIN is enrolled |
| svc_ok | output | 1 | Requested service is granted |

## Verification
The directed patterns show the difference between three kinds of refusal: a wrong PIN, a right PIN asking for a role it does not hold, and a request for the empty role. Runs of four and of five misses, with and without a success placed between them, mark the exact lockout edge, the reset of the counter after a success, and the fresh count after a release. Attempts during the lockout window, repeated enrollments and wipes test the cases where input must be ignored. A random phase then mixes all inputs, and a behavioural reference model is compared against every output on every clock.

// File: rtl/pin_guard_pkg.sv
// Shared role encoding and helpers for the PIN guard.
// Assumes roles are a two-bit set: bit 0 user, bit 1 officer.
package pin_guard_pkg;

    localparam int ROLE_W = 2;
    localparam int SVC_W  = 3;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_NONE    = 2'b00,
        ROLE_USER    = 2'b01,
        ROLE_OFFICER = 2'b10,
        ROLE_BOTH    = 2'b11
    } role_e;

    // True when want is a nonzero subset of have.
    function automatic logic role_covers(logic [ROLE_W-1:0] have, logic [ROLE_W-1:0] want);
        return (want != '0) && ((want & ~have) == '0);
    endfunction

endpackage

// File: rtl/pin_enroll_store.sv
// Holds the single enrolled PIN and its role.
// Accepts one enrollment when empty; a wipe or reset empties it.
module pin_enroll_store
    import pin_guard_pkg::*;
#(
    parameter int PIN_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe_i,
    input  logic              enr_valid_i,
    input  logic [PIN_W-1:0]  enr_pin_i,
    input  logic [ROLE_W-1:0] enr_role_i,
    output logic [PIN_W-1:0]  pin_o,
    output logic [ROLE_W-1:0] role_o,
    output logic              enrolled_o
);

    // Capture first valid enrollment, clear on reset or wipe.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_i) begin
            enrolled_o <= 1'b0;
            pin_o      <= '0;
            role_o     <= ROLE_NONE;
        end else if (enr_valid_i && !enrolled_o && (enr_role_i != ROLE_NONE)) begin
            enrolled_o <= 1'b1;
            pin_o      <= enr_pin_i;
            role_o     <= enr_role_i;
        end
    end

endmodule

// File: rtl/pin_fail_tracker.sv
// Counts consecutive misses; at MAX_FAIL raises a pending zeroize
// that lasts HOLD cycles, after which the count restarts.
// Assumes hit and miss are never high together.
module pin_fail_tracker #(
    parameter int MAX_FAIL = 5,
    parameter int HOLD     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe_i,
    input  logic hit_i,
    input  logic miss_i,
    output logic pending_o
);

    localparam int CW = $clog2(MAX_FAIL + 1);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST_MISS = CW'(MAX_FAIL - 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD - 1);

    logic [CW-1:0] miss_cnt;
    logic [HW-1:0] hold_cnt;

    // Miss counting, lockout entry and timed release.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_i) begin
            miss_cnt  <= '0;
            hold_cnt  <= '0;
            pending_o <= 1'b0;
        end else if (pending_o) begin
            if (hold_cnt == HOLD_LAST) begin
                pending_o <= 1'b0;
                miss_cnt  <= '0;
                hold_cnt  <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end else if (hit_i) begin
            miss_cnt <= '0;
        end else if (miss_i) begin
            miss_cnt <= miss_cnt + 1'b1;
            if (miss_cnt == LAST_MISS) begin
                pending_o <= 1'b1;
                hold_cnt  <= '0;
            end
        end
    end

endmodule

// File: rtl/pin_session.sv
// Judges each attempt against the enrolled PIN and holds the one
// active session role; emits one-cycle grant/refuse pulses.
// Assumes attempts during a pending zeroize must be dropped.
module pin_session
    import pin_guard_pkg::*;
#(
    parameter int PIN_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe_i,
    input  logic              try_valid_i,
    input  logic [PIN_W-1:0]  try_pin_i,
    input  logic [ROLE_W-1:0] try_role_i,
    input  logic [PIN_W-1:0]  ref_pin_i,
    input  logic [ROLE_W-1:0] ref_role_i,
    input  logic              enrolled_i,
    input  logic              pending_i,
    output logic [ROLE_W-1:0] role_o,
    output logic              ok_o,
    output logic              fail_o,
    output logic              hit_o,
    output logic              miss_o
);

    logic take;
    logic match;

    // Verdict for the attempt presented this cycle.
    always_comb begin
        take   = try_valid_i && !pending_i;
        match  = enrolled_i && (try_pin_i == ref_pin_i) && role_covers(ref_role_i, try_role_i);
        hit_o  = take && match;
        miss_o = take && enrolled_i && !match;
    end

    // Session role and response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe_i) begin
            role_o <= ROLE_NONE;
            ok_o   <= 1'b0;
            fail_o <= 1'b0;
        end else begin
            ok_o   <= take && match;
            fail_o <= take && !match;
            if (take) begin
                role_o <= match ? try_role_i : ROLE_NONE;
            end
        end
    end

endmodule

// File: rtl/pin_svc_gate.sv
// Maps a service code and the session role to a grant.
// Codes 0-3 open to all; 4-5 need user bit; 6-7 need officer bit.
module pin_svc_gate
    import pin_guard_pkg::*;
(
    input  logic [SVC_W-1:0]  svc_sel_i,
    input  logic [ROLE_W-1:0] role_i,
    output logic              grant_o
);

    // Decode service class from the upper code bits.
    always_comb begin
        unique case (svc_sel_i[SVC_W-1 -: 2])
            2'b10:   grant_o = role_i[0];
            2'b11:   grant_o = role_i[1];
            default: grant_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/pin_guard.sv
// Top of the PIN authentication and lockout controller.
// Assumes one operator port; rst_n is the power-on reset.
module pin_guard
    import pin_guard_pkg::*;
#(
    parameter int PIN_W    = 24,
    parameter int MAX_FAIL = 5,
    parameter int HOLD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             try_valid,
    input  logic [PIN_W-1:0] try_pin,
    input  logic [1:0]       try_role,
    input  logic             enroll_valid,
    input  logic [PIN_W-1:0] enroll_pin,
    input  logic [1:0]       enroll_role,
    input  logic             wipe_all,
    input  logic [2:0]       svc_sel,
    output logic [1:0]       role,
    output logic             auth_ok,
    output logic             auth_fail,
    output logic             zeroize_req,
    output logic             enroll_needed,
    output logic             svc_ok
);

    logic [PIN_W-1:0]  ref_pin;
    logic [ROLE_W-1:0] ref_role;
    logic              enrolled;
    logic              pending;
    logic              hit;
    logic              miss;

    pin_enroll_store #(.PIN_W(PIN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wipe_i(wipe_all),
        .enr_valid_i(enroll_valid), .enr_pin_i(enroll_pin), .enr_role_i(enroll_role),
        .pin_o(ref_pin), .role_o(ref_role), .enrolled_o(enrolled)
    );

    pin_session #(.PIN_W(PIN_W)) u_sess (
        .clk(clk), .rst_n(rst_n), .wipe_i(wipe_all),
        .try_valid_i(try_valid), .try_pin_i(try_pin), .try_role_i(try_role),
        .ref_pin_i(ref_pin), .ref_role_i(ref_role), .enrolled_i(enrolled),
        .pending_i(pending), .role_o(role), .ok_o(auth_ok), .fail_o(auth_fail),
        .hit_o(hit), .miss_o(miss)
    );

    pin_fail_tracker #(.MAX_FAIL(MAX_FAIL), .HOLD(HOLD_CYC)) u_track (
        .clk(clk), .rst_n(rst_n), .wipe_i(wipe_all),
        .hit_i(hit), .miss_i(miss), .pending_o(pending)
    );

    pin_svc_gate u_gate (
        .svc_sel_i(svc_sel), .role_i(role), .grant_o(svc_ok)
    );

    assign zeroize_req   = pending;
    assign enroll_needed = !enrolled;

endmodule

// File: rtl/pin_guard_chk.sv
// Port-level properties of pin_guard, attached by bind.
module pin_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wipe_all,
    input logic [2:0] svc_sel,
    input logic [1:0] role,
    input logic       auth_ok,
    input logic       auth_fail,
    input logic       zeroize_req,
    input logic       enroll_needed,
    input logic       svc_ok
);

    AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(auth_ok && auth_fail)); // R4
    AST_OK_HAS_ROLE: assert property (@(posedge clk) disable iff (!rst_n) auth_ok |-> (role != 2'b00)); // R4
    AST_FAIL_NO_ROLE: assert property (@(posedge clk) disable iff (!rst_n) auth_fail |-> (role == 2'b00)); // R5
    AST_UNENROLLED_NO_ROLE: assert property (@(posedge clk) disable iff (!rst_n) enroll_needed |-> (role == 2'b00)); // R3
    AST_LOCK_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n) $rose(zeroize_req) |-> auth_fail); // R6
    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (zeroize_req && $past(zeroize_req)) |-> (!auth_ok && !auth_fail)); // R8
    AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wipe_all |=> (enroll_needed && role == 2'b00 && !zeroize_req)); // R9
    AST_OPEN_SVC: assert property (@(posedge clk) disable iff (!rst_n) (svc_sel < 3'd4) |-> svc_ok); // R10

endmodule

bind pin_guard pin_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wipe_all(wipe_all), .svc_sel(svc_sel),
    .role(role), .auth_ok(auth_ok), .auth_fail(auth_fail),
    .zeroize_req(zeroize_req), .enroll_needed(enroll_needed), .svc_ok(svc_ok)
);

// File: tb/pin_guard_tb_top.sv
module pin_guard_tb_top;

    localparam int CLK_P    = 10;
    localparam int PIN_W    = 24;
    localparam int MAX_FAIL = 5;
    localparam int HOLD_CYC = 4;
    localparam logic [PIN_W-1:0] PIN_A = 24'hA5C3F1;
    localparam logic [PIN_W-1:0] PIN_B = 24'h0F0E0D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic try_valid = 1'b0;
    logic [PIN_W-1:0] try_pin = '0;
    logic [1:0] try_role = 2'b00;
    logic enroll_valid = 1'b0;
    logic [PIN_W-1:0] enroll_pin = '0;
    logic [1:0] enroll_role = 2'b00;
    logic wipe_all = 1'b0;
    logic [2:0] svc_sel = 3'd0;
    logic [1:0] role;
    logic auth_ok, auth_fail, zeroize_req, enroll_needed, svc_ok;

    int n_chk = 0;
    int n_err = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    bit m_en, m_ok, m_fail, m_pend;
    logic [PIN_W-1:0] m_pin;
    logic [1:0] m_erole, m_cur;
    int m_cnt, m_hold;

    always #(CLK_P/2) clk = ~clk;

    pin_guard #(.PIN_W(PIN_W), .MAX_FAIL(MAX_FAIL), .HOLD_CYC(HOLD_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .try_valid(try_valid), .try_pin(try_pin), .try_role(try_role),
        .enroll_valid(enroll_valid), .enroll_pin(enroll_pin), .enroll_role(enroll_role),
        .wipe_all(wipe_all), .svc_sel(svc_sel), .role(role), .auth_ok(auth_ok),
        .auth_fail(auth_fail), .zeroize_req(zeroize_req), .enroll_needed(enroll_needed),
        .svc_ok(svc_ok)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, stepped on each rising edge.
    always @(posedge clk) begin
        bit take, good;
        started = 1;
        if (!rst_n || wipe_all) begin
            m_en = 0; m_pin = '0; m_erole = 2'b00; m_cur = 2'b00;
            m_ok = 0; m_fail = 0; m_cnt = 0; m_pend = 0; m_hold = 0;
        end else begin
            take = try_valid && !m_pend;
            good = m_en && (try_pin == m_pin) && (try_role != 2'b00) && ((try_role & ~m_erole) == 2'b00);
            if (m_pend) begin
                m_hold++;
                if (m_hold == HOLD_CYC) begin m_pend = 0; m_cnt = 0; m_hold = 0; end
            end else if (take && good) begin
                m_cnt = 0;
            end else if (take && m_en) begin
                m_cnt++;
                if (m_cnt == MAX_FAIL) begin m_pend = 1; m_hold = 0; end
            end
            m_ok = take && good;
            m_fail = take && !good;
            if (take) m_cur = good ? try_role : 2'b00;
            if (enroll_valid && !m_en && enroll_role != 2'b00) begin
                m_en = 1; m_pin = enroll_pin; m_erole = enroll_role;
            end
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            logic exp_svc;
            if (svc_sel < 3'd4) exp_svc = 1'b1;
            else if (svc_sel < 3'd6) exp_svc = m_cur[0];
            else exp_svc = m_cur[1];
            check("R4 R5 model role", 32'(role), 32'(m_cur));
            check("R4 model auth_ok", 32'(auth_ok), 32'(m_ok));
            check("R5 model auth_fail", 32'(auth_fail), 32'(m_fail));
            check("R6 model zeroize_req", 32'(zeroize_req), 32'(m_pend));
            check("R2 model enroll_needed", 32'(enroll_needed), 32'(!m_en));
            check("R10 model svc_ok", 32'(svc_ok), 32'(exp_svc));
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        try_valid = 0; enroll_valid = 0; wipe_all = 0;
    endtask

    task automatic attempt(logic [PIN_W-1:0] p, logic [1:0] r);
        try_valid = 1; try_pin = p; try_role = r;
        step();
    endtask

    task automatic enroll(logic [PIN_W-1:0] p, logic [1:0] r);
        enroll_valid = 1; enroll_pin = p; enroll_role = r;
        step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) step();
        check("R1 reset role", 32'(role), 32'h0);
        check("R1 reset zeroize", 32'(zeroize_req), 32'h0);
        check("R1 reset enroll_needed", 32'(enroll_needed), 32'h1);
        rst_n = 1;
        step();
        check("R1 after reset ok", 32'(auth_ok), 32'h0);

        // unenrolled attempts
        attempt(24'h123456, 2'b01);
        check("R3 unenrolled fail pulse", 32'(auth_fail), 32'h1);
        check("R3 unenrolled role", 32'(role), 32'h0);
        step();
        check("R3 pulse one cycle", 32'(auth_fail), 32'h0);

        enroll(PIN_A, 2'b00);
        check("R2 empty role ignored", 32'(enroll_needed), 32'h1);
        enroll(PIN_A, 2'b11);
        check("R2 enrolled", 32'(enroll_needed), 32'h0);
        check("R2 no role on enroll", 32'(role), 32'h0);
        enroll(PIN_B, 2'b01);
        attempt(PIN_A, 2'b10);
        check("R2 second enroll ignored", 32'(auth_ok), 32'h1);

        attempt(PIN_A, 2'b01);
        check("R4 user grant", 32'(role), 32'h1);
        svc_sel = 3'd4; step();
        check("R10 user svc 4", 32'(svc_ok), 32'h1);
        svc_sel = 3'd6; step();
        check("R10 officer svc denied", 32'(svc_ok), 32'h0);
        attempt(PIN_A, 2'b11);
        check("R4 both grant", 32'(role), 32'h3);

        attempt(PIN_B, 2'b01);
        check("R5 wrong pin drops role", 32'(role), 32'h0);
        check("R5 wrong pin fail", 32'(auth_fail), 32'h1);
        attempt(PIN_A, 2'b00);
        check("R4 empty role refused", 32'(auth_fail), 32'h1);
        attempt(PIN_B, 2'b01);
        attempt(PIN_B, 2'b01);
        attempt(PIN_A, 2'b01);
        check("R7 success after four misses", 32'(auth_ok), 32'h1);
        for (int i = 0; i < MAX_FAIL - 1; i++) attempt(PIN_B, 2'b10);
        check("R7 count restarted", 32'(zeroize_req), 32'h0);
        attempt(PIN_B, 2'b10);
        check("R6 lockout raised", 32'(zeroize_req), 32'h1);
        check("R6 lockout with fail", 32'(auth_fail), 32'h1);
        attempt(PIN_A, 2'b01);
        check("R8 attempt ignored ok", 32'(auth_ok), 32'h0);
        check("R8 attempt ignored fail", 32'(auth_fail), 32'h0);
        check("R8 role unchanged", 32'(role), 32'h0);
        step(); step();
        check("R6 still held", 32'(zeroize_req), 32'h1);
        step();
        check("R6 released", 32'(zeroize_req), 32'h0);
        check("R11 enrollment kept", 32'(enroll_needed), 32'h0);
        for (int i = 0; i < MAX_FAIL - 1; i++) attempt(PIN_B, 2'b01);
        check("R11 fresh count", 32'(zeroize_req), 32'h0);
        attempt(PIN_B, 2'b01);
        check("R11 relock", 32'(zeroize_req), 32'h1);
        repeat (HOLD_CYC) step();

        attempt(PIN_A, 2'b10);
        wipe_all = 1; step();
        check("R9 wipe role", 32'(role), 32'h0);
        check("R9 wipe enroll_needed", 32'(enroll_needed), 32'h1);
        attempt(PIN_A, 2'b10);
        check("R9 old pin refused", 32'(auth_fail), 32'h1);
        enroll(PIN_B, 2'b01);
        attempt(PIN_B, 2'b10);
        check("R4 role outside enrolled refused", 32'(auth_fail), 32'h1);

        // random mix checked against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            svc_sel = 3'($urandom_range(0, 7));
            try_valid = (r < 45);
            try_pin = (r % 3 == 0) ? PIN_B : ((r % 3 == 1) ? PIN_A : PIN_B ^ 24'h1);
            try_role = 2'($urandom_range(0, 3));
            enroll_valid = (r > 80);
            enroll_pin = (r % 2 == 0) ? PIN_A : PIN_B;
            enroll_role = 2'($urandom_range(0, 3));
            wipe_all = (r == 99);
            step();
        end
        step();
        finish_run();
    end

endmodule